// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls a bank of 32 general-purpose pins. Each pin is owned either by the GPIO logic or by one of two internal peripheral functions, A or B. When GPIO owns a pin, the pad's output level and output enable come from GPIO registers. When a peripheral owns it, they come straight from that peripheral's inputs to the block. An open-drain option turns any driving source into a pull-low-only driver. A pull-up control goes out to the pad for every pin.

Software changes each per-pin attribute through a pair of write-only registers. Writing a 1 into the "set" register sets that pin's attribute. Writing a 1 into the "clear" register clears it. Zero bits leave pins alone, so no read-modify-write is ever needed. A status register beside each pair returns the attribute vector. One more status register returns the synchronized, optionally de-glitched pad levels, whatever the pin's owner. The register window is 512 bytes on a simple single-cycle 32-bit bus: one write strobe, and read data that follows the address combinationally.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, every pin is owned by GPIO, pull-ups are on, and output enable, output data, glitch filter, open-drain and peripheral select (A) are all 0. pad_oe reads all 0 and pad_pull_up reads all 1.
- R2: Attribute k sits at byte offset 16*k: +0 set, +4 clear, +8 status. The attributes are k=0 GPIO ownership (1 = GPIO), 1 output enable, 2 output data, 3 pull-up, 4 glitch filter, 5 open-drain, 6 peripheral select (set selects B, clear selects A, status 1 = B). Offset 0x78 returns the pin levels. Bit n of every register is pin n. A decoded address has bus_addr[1:0] = 0. Any other read returns 0.
- R3: A write to a set register sets exactly the pins whose data bit is 1, and a write to a clear register clears exactly those pins. Zero bits leave pins unchanged. All addressed pins update on the same clock edge.
- R4: Status reads are combinational and return the register contents after every write edge.
- R5: For a GPIO-owned pin without open-drain, pad_out equals its output-data bit and pad_oe equals its output-enable bit.
- R6: For a peripheral-owned pin without open-drain, pad_out and pad_oe follow per_a_out/per_a_oe when select is 0 and per_b_out/per_b_oe when select is 1. This path is combinational from those inputs.
- R7: With open-drain on, pad_out is 0 and pad_oe is 1 only when the selected source enables its output and drives 0.
- R8: pad_pull_up equals the pull-up status for every pin, whoever owns it.
- R9: With the filter off, a pad level change made before rising edge e1 shows in the pin-level register after edge e3 and not before. This does not depend on ownership or on writes in the same cycle.
- R10: With the filter on, a level is taken only when two consecutive synchronized samples agree. A stable change appears after edge e4 and not after e3. A one-cycle pulse never appears. Each pin is filtered independently.
- R11: Writes to status addresses, to the pin-level address, to offsets past 0x78 or to unaligned addresses change no attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 9 | Byte address in the 512-byte window |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| per_a_out | input | 32 | Peripheral A output levels |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_b_out | input | 32 | Peripheral B output levels |
| per_b_oe | input | 32 | Peripheral B output enables |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| pad_pull_up | output | 32 | Pad pull-up enable |

## Verification
Two things can happen in the same cycle: a register write that changes who owns a pin, and a pad transition that the synchronizer is taking in. The bench launches a pad pattern on the same clock edge as an ownership-clear write. It requires the pin level to appear exactly three edges later, as if no write had happened. In the filtered case, a one-cycle pulse is applied with the filter enabled on only half of the pins. Each pin is then judged against the edge count that its own filter setting predicts.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NATTR   = 7;
  localparam int A_OWN   = 0;
  localparam int A_OE    = 1;
  localparam int A_DAT   = 2;
  localparam int A_PU    = 3;
  localparam int A_FLT   = 4;
  localparam int A_OD    = 5;
  localparam int A_SEL   = 6;
  localparam int LVL_IDX = 7;
  localparam logic [1:0] SUB_SET  = 2'd0;
  localparam logic [1:0] SUB_CLR  = 2'd1;
  localparam logic [1:0] SUB_STAT = 2'd2;

  // attributes that come out of reset all ones
  function automatic bit attr_rst_ones(int k);
    return (k == A_OWN) || (k == A_PU);
  endfunction

  // per-pin driver choice; returns {level, enable}
  function automatic logic [1:0] pin_drive(logic own, logic selb, logic od,
                                           logic dat, logic oe,
                                           logic ao, logic ae,
                                           logic bo, logic be);
    logic v, e;
    if (own)       begin v = dat; e = oe; end
    else if (selb) begin v = bo;  e = be; end
    else           begin v = ao;  e = ae; end
    if (od) return {1'b0, e & ~v};
    return {v, e};
  endfunction
endpackage

// File: rtl/gpio_attr_reg.sv
module gpio_attr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= RST_VAL;
    else if (set_stb) q <= q | mask;
    else if (clr_stb) q <= q & ~mask;
  end

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(mask)) == $past(mask)));
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(mask)) == '0));
  assert_others_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(q));
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] flt_en,
  output logic [W-1:0] lvl
);
  logic [W-1:0] s1, s2, s3;
  logic [W-1:0] hold_mask;   // pins whose filter rejects this sample
  logic [W-1:0] lvl_nxt;

  assign hold_mask = flt_en & (s2 ^ s3);
  assign lvl_nxt   = (lvl & hold_mask) | (s2 & ~hold_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; lvl <= '0;
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      lvl <= lvl_nxt;
    end
  end

  assert_lvl_from_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl ^ $past(lvl)) & (lvl ^ $past(s2))) == '0));
  assert_filter_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mask != '0) |=> ((lvl & $past(hold_mask)) == ($past(lvl) & $past(hold_mask))));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] selb,
  input  logic [W-1:0] od,
  input  logic [W-1:0] dat,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] a_out,
  input  logic [W-1:0] a_oe,
  input  logic [W-1:0] b_out,
  input  logic [W-1:0] b_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] drv;
    assign drv = gpio_bank_pkg::pin_drive(own[i], selb[i], od[i], dat[i], oe[i],
                                          a_out[i], a_oe[i], b_out[i], b_oe[i]);
    assign pad_out[i] = drv[1];
    assign pad_oe[i]  = drv[0];
  end
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NPIN-1:0]   per_a_out,
  input  logic [NPIN-1:0]   per_a_oe,
  input  logic [NPIN-1:0]   per_b_out,
  input  logic [NPIN-1:0]   per_b_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pull_up
);
  import gpio_bank_pkg::*;

  localparam int IDX_W = ADDR_W - 4;

  logic             word_ok;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sub;
  logic [NATTR-1:0] set_stb, clr_stb;
  logic [NATTR-1:0][NPIN-1:0] attr_q;
  logic [NPIN-1:0]  lvl;
  logic             attr_write;   // a write that targets a set/clear register

  assign word_ok    = (bus_addr[1:0] == 2'b00);
  assign idx        = bus_addr[ADDR_W-1:4];
  assign sub        = bus_addr[3:2];
  assign attr_write = |set_stb || |clr_stb;

  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    assign set_stb[k] = bus_we && word_ok && (idx == IDX_W'(k)) && (sub == SUB_SET);
    assign clr_stb[k] = bus_we && word_ok && (idx == IDX_W'(k)) && (sub == SUB_CLR);
    gpio_attr_reg #(
      .W       (NPIN),
      .RST_VAL (attr_rst_ones(k) ? {NPIN{1'b1}} : {NPIN{1'b0}})
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb[k]),
      .clr_stb (clr_stb[k]),
      .mask    (bus_wdata),
      .q       (attr_q[k])
    );
  end

  gpio_in_filter #(.W(NPIN)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .flt_en (attr_q[A_FLT]),
    .lvl    (lvl)
  );

  gpio_pad_mux #(.W(NPIN)) u_mux (
    .own     (attr_q[A_OWN]),
    .selb    (attr_q[A_SEL]),
    .od      (attr_q[A_OD]),
    .dat     (attr_q[A_DAT]),
    .oe      (attr_q[A_OE]),
    .a_out   (per_a_out),
    .a_oe    (per_a_oe),
    .b_out   (per_b_out),
    .b_oe    (per_b_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_pull_up = attr_q[A_PU];

  always_comb begin
    bus_rdata = '0;
    if (word_ok && sub == SUB_STAT) begin
      if (idx < IDX_W'(NATTR))         bus_rdata = attr_q[idx[2:0]];
      else if (idx == IDX_W'(LVL_IDX)) bus_rdata = lvl;
    end
  end

  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !attr_write) |=> $stable(attr_q));
  assert_od_never_drives_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & attr_q[A_OD]) == '0));
  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb}));
endmodule

// File: tb/test_gpio_mux_bank.sv
module test_gpio_mux_bank;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] per_a_out = 32'h3C3C_3C3C, per_a_oe = 32'hFFFF_0000;
  logic [NP-1:0] per_b_out = 32'h1234_5678, per_b_oe = 32'h0F0F_0F0F;
  logic [NP-1:0] pad_out, pad_oe, pad_pull_up;

  always #4 clk = ~clk;

  gpio_mux_bank i_gpio_mux_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .per_a_out(per_a_out), .per_a_oe(per_a_oe),
    .per_b_out(per_b_out), .per_b_oe(per_b_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up));

  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] mdl [7];
  logic [NP-1:0] bg  [7];

  function automatic logic [8:0] ra(int k, int s);
    return 9'(k * 16 + s * 4);
  endfunction

  task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [NP-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [NP-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic mset(int k, logic [NP-1:0] d);
    wr(ra(k, 0), d); mdl[k] = mdl[k] | d;
  endtask

  task automatic mclr(int k, logic [NP-1:0] d);
    wr(ra(k, 1), d); mdl[k] = mdl[k] & ~d;
  endtask

  task automatic check_pads(string tag);
    logic [NP-1:0] so, se, eo, ee;
    #1;
    so = (mdl[0] & mdl[2]) | (~mdl[0] & ~mdl[6] & per_a_out) | (~mdl[0] & mdl[6] & per_b_out);
    se = (mdl[0] & mdl[1]) | (~mdl[0] & ~mdl[6] & per_a_oe)  | (~mdl[0] & mdl[6] & per_b_oe);
    eo = so & ~mdl[5];
    ee = (se & ~mdl[5]) | (se & mdl[5] & ~so);
    chk({tag, " R5 R6 R7 pad_out"}, pad_out, eo);
    chk({tag, " R5 R6 R7 pad_oe"}, pad_oe, ee);
    chk({tag, " R8 pad_pull_up"}, pad_pull_up, mdl[3]);
  endtask

  task automatic check_regs(string tag);
    logic [NP-1:0] v;
    for (int k = 0; k < 7; k++) begin
      rd(ra(k, 2), v);
      chk($sformatf("%s R2 R4 attr%0d status", tag, k), v, mdl[k]);
    end
  endtask

  task automatic lvl_is(string tag, logic [NP-1:0] exp);
    logic [NP-1:0] v;
    rd(ra(7, 2), v);
    chk(tag, v, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    logic [NP-1:0] pat;
    for (int k = 0; k < 7; k++) mdl[k] = (k == 0 || k == 3) ? '1 : '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_regs("R1 reset");
    check_pads("R1 reset");
    chk("R1 pad_oe after reset", pad_oe, '0);
    lvl_is("R1 level after reset", '0);

    // R2 unmapped and unaligned reads
    rd(9'h080, v); chk("R2 unmapped read", v, '0);
    rd(9'h1F8, v); chk("R2 high unmapped read", v, '0);
    rd(9'h00A, v); chk("R2 unaligned read", v, '0);

    // background configuration
    bg[0] = 32'h0000_FFFF; bg[1] = 32'h00FF_00FF; bg[2] = 32'h0F0F_0F0F;
    bg[3] = 32'hAAAA_5555; bg[4] = 32'h0000_0000; bg[5] = 32'h3300_3300;
    bg[6] = 32'h00FF_00FF;
    for (int k = 0; k < 7; k++) begin
      mset(k, bg[k]); mclr(k, ~bg[k]);
    end
    check_regs("R3 background");
    check_pads("R5 background");

    // R3 walk each attribute across every pin
    for (int k = 0; k < 7; k++) begin
      mclr(k, '1);
      for (int i = 0; i < NP; i++) begin
        mset(k, NP'(1) << i);
        rd(ra(k, 2), v);
        chk($sformatf("R3 set walk attr%0d pin%0d", k, i), v, mdl[k]);
        check_pads("R3 walk");
      end
      mclr(k, 32'hA5A5_A5A5);
      rd(ra(k, 2), v); chk("R3 multi clear", v, 32'h5A5A_5A5A);
      mset(k, 32'h0000_00F0);
      rd(ra(k, 2), v); chk("R3 multi set", v, 32'h5A5A_5AFA);
      mset(k, '0); mclr(k, '0);
      rd(ra(k, 2), v); chk("R3 zero write no effect", v, 32'h5A5A_5AFA);
      check_pads("R3 multi");
      mset(k, bg[k]); mclr(k, ~bg[k]);
    end

    // R6 peripheral input changes with config fixed
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      per_a_out = 32'h9E37_79B9 * (j + 1); per_a_oe = ~per_a_out ^ 32'h0F0F_F0F0;
      per_b_out = 32'h7F4A_7C15 * (j + 3); per_b_oe = per_b_out ^ 32'h3333_CCCC;
      check_pads("R6 peripheral inputs");
    end

    // R7 open-drain over all pins
    mset(5, '1);
    check_pads("R7 open-drain all");
    mclr(5, '1); mset(5, bg[5]);

    // R11 writes to status, level, unmapped and unaligned addresses
    wr(ra(2, 2), '0);
    wr(ra(0, 2), '0);
    wr(ra(7, 2), '1);
    wr(ra(7, 0), '1);
    wr(9'h090, '1);
    wr(9'h001, '1);
    wr(9'h012, '1);
    check_regs("R11 ignored writes");
    check_pads("R11 ignored writes");

    // R9 unfiltered latency, with an ownership write on the same edge
    mclr(4, '1);
    repeat (4) @(negedge clk);
    pat = '0;
    for (int j = 0; j < 6; j++) begin
      pat = 32'hC6A4_A793 * (j + 1) ^ 32'h5BD1_E995;
      @(negedge clk);
      pad_in = pat;
      bus_we = 1'b1; bus_addr = ra(0, j % 2); bus_wdata = 32'hFFFF_0000;
      mdl[0] = (j % 2 == 0) ? (mdl[0] | 32'hFFFF_0000) : (mdl[0] & 32'h0000_FFFF);
      @(negedge clk);
      bus_we = 1'b0;
      @(negedge clk);
      lvl_is("R9 level unchanged after 2 edges", pat ^ (pat ^ (32'hC6A4_A793 * j ^ 32'h5BD1_E995)) & {NP{j != 0}} ^ ((j == 0) ? pat : '0));
      @(negedge clk);
      lvl_is("R9 level after 3 edges", pat);
    end
    check_regs("R9 ownership during sampling");

    // R10 filtered: stable change takes 4 edges
    mset(4, '1);
    @(negedge clk);
    pad_in = 32'h0000_0000;
    repeat (6) @(negedge clk);
    lvl_is("R10 settle", '0);
    pad_in = 32'hF0F0_1234;
    repeat (3) @(negedge clk);
    lvl_is("R10 not after 3 edges", '0);
    @(negedge clk);
    lvl_is("R10 after 4 edges", 32'hF0F0_1234);

    // R10 one-cycle pulse, filter on low half only
    mclr(4, 32'hFFFF_0000);
    repeat (3) @(negedge clk);
    pad_in = 32'hF0F0_1234 ^ 32'hFFFF_FFFF;
    @(negedge clk);
    pad_in = 32'hF0F0_1234;
    lvl_is("R10 pulse n1", 32'hF0F0_1234);
    @(negedge clk);
    lvl_is("R10 pulse n2", 32'hF0F0_1234);
    @(negedge clk);
    lvl_is("R9 R10 pulse n3 unfiltered half only", 32'h0F0F_1234);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      lvl_is("R10 pulse rejected on filtered half", 32'hF0F0_1234);
    end

    summary();
    $finish;
  end
endmodule